// File: doc/BRIEF.md
# Receive Statistics Counter Bank

This block counts receive-side frame events in 64-bit counters and presents them, along with a few identification and control words, through a simple 32-bit word-addressed register port. A receive MAC drives one strobe when a frame begins. It drives another when the frame ends, together with the frame's byte length and a decode-error flag. The bank counts frame starts. It also counts runt frames, meaning frames that ended with a length inside a fixed window.

Software can freeze every readable counter into a snapshot that is taken on a single clock edge. While the snapshot is held, the live counters keep running, and the low and high halves of each counter always belong together. A single configuration write can also clear all counters at once, or drop a sticky parity-error status flag. The bank also holds a revision word, a scratch word and a 12-character ASCII identifier, "RxStatCount1".

Top module: `rx_stat_bank`

## Requirements
- R1: A frame end (`ev_eof`) with length 9 to 63 bytes inclusive and `ev_dec_err` low increments the runt counter by one on that clock edge; lengths of 64 or more leave it unchanged.
- R2: A frame end with length 8 or less, or with `ev_dec_err` high, is a decode error and never increments the runt counter.
- R3: Each `ev_sof` strobe increments the frame-start counter by one.
- R4: Counters are read as two words: runt low at 0x34 and high at 0x35, frame-start low at 0x36 and high at 0x37. Read data appears on `reg_rdata` with `reg_rvalid` one cycle after `reg_rd`.
- R5: Writing config (0x45) with bit 2 set captures every counter on the write edge. Counter reads then return the captured values while the live counts keep advancing, and writing bit 2 as 0 returns reads to the live values.
- R6: Writing config bit 0 as 1 zeroes all counters and snapshots on the following edge, and this clear beats an increment in that same cycle. Bit 0 then clears itself.
- R7: Status (0x46) bit 0 is set by a `par_err` pulse and stays set. Writing config bit 1 as 1 clears it on the following edge, and bit 1 clears itself.
- R8: The scratch word at 0x41 is read/write and resets to 0x00000009.
- R9: The revision word (0x40) and the identifier words (0x42, 0x43, 0x44) are read-only and ignore writes. They hold "RxStatCount1" with the first character of each word in bits 31:24.
- R10: Reserved offsets read as zero and ignore writes. Config bits 31:3 always read as zero.
- R11: After reset all counters and status read 0, config reads 0, and scratch reads 0x09.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_sof | input | 1 | Frame-start strobe |
| ev_eof | input | 1 | Frame-end strobe |
| ev_len | input | LEN_W | Byte length of the ending frame |
| ev_dec_err | input | 1 | Frame ending now has a decode error |
| par_err | input | 1 | Parity error pulse, sets sticky status |
| reg_addr | input | 8 | Word offset within the bank |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |

## Verification
A counter that missed or double-counted an event, or that cleared at the wrong moment, shows up in the very next counter read, which arrives one cycle after the request. For that reason the bench reads the runt count back after every frame in its length table. A snapshot that was captured late, or that drifted while frozen, shows up as a counter read that differs from the value counted at the freeze. A self-clearing bit that stuck high would keep zeroing the counters or the status flag, and a later read would show that at once.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int unsigned AW = 8;

  localparam logic [AW-1:0] OFF_CNT_BASE = 8'h34;
  localparam logic [AW-1:0] OFF_REV      = 8'h40;
  localparam logic [AW-1:0] OFF_SCR      = 8'h41;
  localparam logic [AW-1:0] OFF_ID0      = 8'h42;
  localparam logic [AW-1:0] OFF_ID1      = 8'h43;
  localparam logic [AW-1:0] OFF_ID2      = 8'h44;
  localparam logic [AW-1:0] OFF_CFG      = 8'h45;
  localparam logic [AW-1:0] OFF_STS      = 8'h46;

  localparam int unsigned CFG_CLR  = 0;
  localparam int unsigned CFG_PCLR = 1;
  localparam int unsigned CFG_SHAD = 2;

  // Length window test: strictly above the decode floor, strictly below the minimum frame
  function automatic logic in_runt_window(input logic [31:0] len,
                                          input int unsigned floor_len,
                                          input int unsigned min_frame);
    return (len > floor_len) && (len < min_frame);
  endfunction

  // Word offsets of a counter's low and high halves
  function automatic logic [AW-1:0] cnt_lo_off(input int unsigned idx);
    return AW'(int'(OFF_CNT_BASE) + 2 * idx);
  endfunction

  function automatic logic [AW-1:0] cnt_hi_off(input int unsigned idx);
    return AW'(int'(OFF_CNT_BASE) + 2 * idx + 1);
  endfunction
endpackage

// File: rtl/rxs_frame_classify.sv
module rxs_frame_classify #(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned FLOOR_LEN = 8,
  parameter int unsigned MIN_FRAME = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_sof,
  input  logic             ev_eof,
  input  logic [LEN_W-1:0] ev_len,
  input  logic             ev_dec_err,
  output logic             runt_hit,
  output logic             sof_hit
);
  import rxs_pkg::*;

  logic len_ok;
  assign len_ok   = in_runt_window(32'(ev_len), FLOOR_LEN, MIN_FRAME);
  assign runt_hit = ev_eof && !ev_dec_err && len_ok;
  assign sof_hit  = ev_sof;

  // R2
  short_frame_not_runt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_eof && (32'(ev_len) <= FLOOR_LEN)) |-> !runt_hit);

  // R2
  dec_err_not_runt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dec_err |-> !runt_hit);
endmodule

// File: rtl/rxs_counter.sv
module rxs_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic             snap_take,
  input  logic             snap_on,
  output logic [CNT_W-1:0] view
);
  logic [CNT_W-1:0] live_q;
  logic [CNT_W-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      live_q <= '0;
    end else if (inc) begin
      live_q <= live_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      snap_q <= '0;
    end else if (snap_take) begin
      snap_q <= live_q;
    end
  end

  assign view = snap_on ? snap_q : live_q;

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (live_q == '0));

  // R1 R3
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (live_q == $past(live_q) + CNT_W'(1)));

  // R5
  snap_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_on && !snap_take && !clr) |=> $stable(snap_q));
endmodule

// File: rtl/rxs_ctrl.sv
module rxs_ctrl #(
  parameter logic [31:0] SCRATCH_INIT = 32'h0000_0009
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  input  logic        par_err,
  output logic        snap_on,
  output logic        snap_take,
  output logic        clr_fire,
  output logic        pclr_fire,
  output logic [31:0] scratch,
  output logic        par_sticky,
  output logic [31:0] cfg_word
);
  import rxs_pkg::*;

  logic cfg_wr, scr_wr;
  assign cfg_wr = reg_wr && (reg_addr == OFF_CFG);
  assign scr_wr = reg_wr && (reg_addr == OFF_SCR);

  // Capture happens only on the write that turns the shadow on
  assign snap_take = cfg_wr && reg_wdata[CFG_SHAD] && !snap_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_on   <= 1'b0;
      clr_fire  <= 1'b0;
      pclr_fire <= 1'b0;
    end else begin
      clr_fire  <= cfg_wr && reg_wdata[CFG_CLR];
      pclr_fire <= cfg_wr && reg_wdata[CFG_PCLR];
      if (cfg_wr) snap_on <= reg_wdata[CFG_SHAD];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scratch <= SCRATCH_INIT;
    end else if (scr_wr) begin
      scratch <= reg_wdata;
    end
  end

  // A new error in the clearing cycle is kept
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_sticky <= 1'b0;
    end else if (par_err) begin
      par_sticky <= 1'b1;
    end else if (pclr_fire) begin
      par_sticky <= 1'b0;
    end
  end

  assign cfg_word = {29'd0, snap_on, pclr_fire, clr_fire};

  // R7
  par_sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> par_sticky);

  // R6
  clr_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire && !cfg_wr) |=> !clr_fire);

  // R7
  pclr_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pclr_fire && !cfg_wr) |=> !pclr_fire);
endmodule

// File: rtl/rx_stat_bank.sv
module rx_stat_bank #(
  parameter int unsigned LEN_W        = 16,
  parameter int unsigned CNT_W        = 64,
  parameter int unsigned FLOOR_LEN    = 8,
  parameter int unsigned MIN_FRAME    = 64,
  parameter logic [31:0] REV_ID       = 32'h0001_0200,
  parameter logic [31:0] SCRATCH_INIT = 32'h0000_0009
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_sof,
  input  logic             ev_eof,
  input  logic [LEN_W-1:0] ev_len,
  input  logic             ev_dec_err,
  input  logic             par_err,
  input  logic [7:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  input  logic             reg_rd,
  output logic [31:0]      reg_rdata,
  output logic             reg_rvalid
);
  import rxs_pkg::*;

  localparam int unsigned NUM_CNT = 2;    // 0: runt, 1: frame start
  localparam logic [95:0] ID_TEXT = "RxStatCount1";

  logic runt_hit, sof_hit;
  logic snap_on, snap_take, clr_fire, pclr_fire, par_sticky;
  logic [31:0] scratch, cfg_word;
  logic [NUM_CNT-1:0] inc_vec;
  logic [NUM_CNT-1:0][CNT_W-1:0] view;

  rxs_frame_classify #(
    .LEN_W(LEN_W), .FLOOR_LEN(FLOOR_LEN), .MIN_FRAME(MIN_FRAME)
  ) u_classify (
    .clk(clk), .rst_n(rst_n), .ev_sof(ev_sof), .ev_eof(ev_eof),
    .ev_len(ev_len), .ev_dec_err(ev_dec_err),
    .runt_hit(runt_hit), .sof_hit(sof_hit)
  );

  rxs_ctrl #(.SCRATCH_INIT(SCRATCH_INIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .par_err(par_err),
    .snap_on(snap_on), .snap_take(snap_take), .clr_fire(clr_fire),
    .pclr_fire(pclr_fire), .scratch(scratch), .par_sticky(par_sticky),
    .cfg_word(cfg_word)
  );

  assign inc_vec = {sof_hit, runt_hit};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    rxs_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc_vec[g]), .clr(clr_fire),
      .snap_take(snap_take), .snap_on(snap_on), .view(view[g])
    );
  end

  logic [31:0] rd_nxt;
  always_comb begin
    rd_nxt = '0;
    unique case (reg_addr)
      OFF_REV: rd_nxt = REV_ID;
      OFF_SCR: rd_nxt = scratch;
      OFF_ID0: rd_nxt = ID_TEXT[95:64];
      OFF_ID1: rd_nxt = ID_TEXT[63:32];
      OFF_ID2: rd_nxt = ID_TEXT[31:0];
      OFF_CFG: rd_nxt = cfg_word;
      OFF_STS: rd_nxt = {31'd0, par_sticky};
      default: rd_nxt = '0;
    endcase
    for (int k = 0; k < NUM_CNT; k++) begin
      if (reg_addr == cnt_lo_off(k)) rd_nxt = view[k][31:0];
      if (reg_addr == cnt_hi_off(k)) rd_nxt = 32'(view[k] >> 32);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_nxt;
    end
  end

  // R4
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  // R10
  cfg_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFF_CFG) |=> (reg_rdata[31:3] == '0));
endmodule

// File: tb/rx_stat_bank_tb.sv
module rx_stat_bank_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_sof = 0, ev_eof = 0, ev_dec_err = 0, par_err = 0;
  logic [15:0] ev_len = '0;
  logic [7:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_rvalid;

  int checks = 0;
  int errors = 0;
  int exp_runt = 0;
  int exp_sof = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  rx_stat_bank u_dut (
    .clk(clk), .rst_n(rst_n), .ev_sof(ev_sof), .ev_eof(ev_eof),
    .ev_len(ev_len), .ev_dec_err(ev_dec_err), .par_err(par_err),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );

  // {dec_err, length}
  localparam logic [16:0] VEC [10] = '{
    {1'b0, 16'd30}, {1'b0, 16'd8},  {1'b0, 16'd9},  {1'b0, 16'd63},
    {1'b0, 16'd64}, {1'b0, 16'd0},  {1'b0, 16'd1500}, {1'b1, 16'd12},
    {1'b0, 16'd40}, {1'b0, 16'd7}
  };

  function automatic bit bench_is_runt(input int len, input bit err);
    if (err) return 0;
    return (len >= 9) && (len <= 63);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(posedge clk);
    @(negedge clk); reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk);
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic frame(input int len, input bit err);
    @(negedge clk); ev_sof = 1;
    @(negedge clk); ev_sof = 0; ev_eof = 1; ev_len = 16'(len); ev_dec_err = err;
    @(negedge clk); ev_eof = 0; ev_dec_err = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R11 reset state, R8 scratch init, R9 identity
    rd_reg(8'h34, rd); chk("R11 runt lo", rd, 0);
    rd_reg(8'h36, rd); chk("R11 start lo", rd, 0);
    rd_reg(8'h45, rd); chk("R11 config", rd, 0);
    rd_reg(8'h46, rd); chk("R11 status", rd, 0);
    rd_reg(8'h41, rd); chk("R8 scratch reset", rd, 32'h9);
    rd_reg(8'h40, rd); chk("R9 revision", rd, 32'h0001_0200);
    rd_reg(8'h42, rd); chk("R9 id0", rd, {"R","x","S","t"});
    rd_reg(8'h43, rd); chk("R9 id1", rd, {"a","t","C","o"});
    rd_reg(8'h44, rd); chk("R9 id2", rd, {"u","n","t","1"});

    // R1 R2 R3 length table
    for (int i = 0; i < 10; i++) begin
      frame(int'(VEC[i][15:0]), VEC[i][16]);
      exp_sof++;
      if (bench_is_runt(int'(VEC[i][15:0]), VEC[i][16])) exp_runt++;
      rd_reg(8'h34, rd); chk("R1 R2 runt count", rd, 32'(exp_runt));
    end
    rd_reg(8'h36, rd); chk("R3 start count", rd, 32'(exp_sof));
    rd_reg(8'h35, rd); chk("R4 runt hi", rd, 0);
    rd_reg(8'h37, rd); chk("R4 start hi", rd, 0);

    // R4 read latency
    @(negedge clk); reg_addr = 8'h36; reg_rd = 1;
    @(negedge clk); reg_rd = 0;
    chk("R4 rvalid", {31'd0, reg_rvalid}, 1);
    chk("R4 rdata", reg_rdata, 32'(exp_sof));

    // R8 scratch
    wr_reg(8'h41, 32'hA5C3_0F12);
    rd_reg(8'h41, rd); chk("R8 scratch rw", rd, 32'hA5C3_0F12);

    // R9 R10 read-only and reserved
    wr_reg(8'h40, 32'hFFFF_FFFF);
    rd_reg(8'h40, rd); chk("R9 rev ignores write", rd, 32'h0001_0200);
    wr_reg(8'h42, 32'h0);
    rd_reg(8'h42, rd); chk("R9 id ignores write", rd, {"R","x","S","t"});
    wr_reg(8'h3A, 32'hDEAD_BEEF);
    rd_reg(8'h3A, rd); chk("R10 reserved reads zero", rd, 0);
    rd_reg(8'h41, rd); chk("R10 reserved write no effect", rd, 32'hA5C3_0F12);

    // R5 shadow
    wr_reg(8'h45, 32'h4);
    frame(20, 0); exp_runt++; exp_sof++;
    frame(25, 0); exp_runt++; exp_sof++;
    rd_reg(8'h34, rd); chk("R5 frozen runt", rd, 32'(exp_runt - 2));
    rd_reg(8'h36, rd); chk("R5 frozen start", rd, 32'(exp_sof - 2));
    wr_reg(8'h45, 32'hFFFF_FFF4);
    rd_reg(8'h45, rd); chk("R10 config reserved", rd, 32'h4);
    rd_reg(8'h34, rd); chk("R5 no recapture", rd, 32'(exp_runt - 2));
    wr_reg(8'h45, 32'h0);
    rd_reg(8'h34, rd); chk("R5 live after release", rd, 32'(exp_runt));

    // R7 parity sticky and clear
    @(negedge clk); par_err = 1;
    @(negedge clk); par_err = 0;
    repeat (3) @(negedge clk);
    rd_reg(8'h46, rd); chk("R7 sticky set", rd, 1);
    wr_reg(8'h45, 32'h2);
    rd_reg(8'h46, rd); chk("R7 cleared", rd, 0);
    rd_reg(8'h45, rd); chk("R7 bit self-clears", rd, 0);

    // R6 clear beats a same-cycle increment
    wr_reg(8'h45, 32'h1);
    ev_sof = 1;
    @(negedge clk); ev_sof = 0;
    rd_reg(8'h36, rd); chk("R6 clear beats increment", rd, 0);
    rd_reg(8'h34, rd); chk("R6 runt cleared", rd, 0);
    rd_reg(8'h45, rd); chk("R6 bit self-clears", rd, 0);
    frame(10, 0);
    rd_reg(8'h34, rd); chk("R6 counts after clear", rd, 1);
    rd_reg(8'h36, rd); chk("R3 start after clear", rd, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule